// File: doc/BRIEF.md
# Port Power Switch Guard

This block drives the enable lines of external per-port power switches and watches the over-current flags that those switches return. It serves up to four downstream ports. The host side issues one-cycle set-power and clear-power strobes for each port. A configuration bit selects one of two switching modes. In ganged mode all ports switch together. In individual mode each port switches on its own, and this is the default when the bit is low. The active level of the enable pins and the active level of the over-current pins are each set by a polarity bit.

Each over-current input first passes through a two-flop synchroniser. It is then qualified by a filter that counts 1 ms ticks. The qualification time is a 4-bit value from 0 to 15 ms. Its source depends on the port: a port flagged as enabled uses one value and a port flagged as disabled uses the other. A global switch turns the timer off so that detection is immediate. A qualified over-current has three effects: it raises that port's status, it sets a sticky change bit, and it removes power. Power returns only on a fresh set-power command. When a qualified over-current removes power from a port that was on, the block emits a one-cycle power-off event.

Top module: `port_power_guard`

## Requirements
- R1: While reset is active and just after it, every port is unpowered and all over-current status, change and event outputs read 0.
- R2: With gang_mode low, set_pwr[i] powers port i only and clr_pwr[i] unpowers port i only. When both strobes hit the same port in the same cycle, the clear takes precedence. The new state shows on the pins after the next clock edge.
- R3: With gang_mode high, a set strobe on any port powers every port, a clear strobe on any port unpowers every port, and a qualified over-current on any port unpowers every port.
- R4: pwr_pin[i] equals the port's power state when pwr_act_high is 1, and its inverse when pwr_act_high is 0.
- R5: An over-current input counts as asserted when oc_pin[i] equals oc_act_high, so a low pin asserts when oc_act_high is 0.
- R6: Once the synchronised input is asserted, the over-current qualifies after N tick_1ms pulses have been counted. N is oc_time_en when port_enabled[i] is 1 and oc_time_dis otherwise. oc_status[i] rises on the clock edge after the Nth counted tick, and N = 0 qualifies at once.
- R7: If the synchronised input deasserts before qualification, the tick count restarts from zero.
- R8: With oc_timer_off high, an asserted input qualifies without waiting for any tick, whatever the programmed times.
- R9: A qualified over-current unpowers its port on the same edge that oc_status rises, and this wins over a set strobe in that cycle. The port stays unpowered after the over-current clears, until a new set strobe arrives.
- R10: oc_change[i] is set by a qualified over-current and held until an oc_chg_clr[i] strobe. A set and a clear in the same cycle leave the bit at 1.
- R11: oc_status[i] falls once the synchronised input deasserts. It tracks the current condition, not its history.
- R12: pwr_off_evt pulses for one cycle on the edge where a qualified over-current removes power from a port that was powered. It stays 0 when the affected ports were already off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_pwr | input | NUM_PORTS | Per-port set-power strobe |
| clr_pwr | input | NUM_PORTS | Per-port clear-power strobe |
| gang_mode | input | 1 | 1: all ports switch together |
| pwr_act_high | input | 1 | Active level of pwr_pin |
| oc_act_high | input | 1 | Active level of oc_pin |
| oc_time_en | input | TIME_W | Qualification ticks for an enabled port |
| oc_time_dis | input | TIME_W | Qualification ticks for a disabled port |
| oc_timer_off | input | 1 | 1: qualify without waiting |
| port_enabled | input | NUM_PORTS | Per-port enabled flag |
| tick_1ms | input | 1 | One-cycle millisecond tick |
| oc_pin | input | NUM_PORTS | Raw over-current flags from the switches |
| oc_chg_clr | input | NUM_PORTS | Per-port strobe clearing oc_change |
| pwr_pin | output | NUM_PORTS | Power switch enable pins |
| oc_status | output | NUM_PORTS | Qualified over-current, current level |
| oc_change | output | NUM_PORTS | Sticky over-current change bits |
| pwr_off_evt | output | 1 | Pulse when an over-current removes power |

## Verification
Two collisions are provoked. In the first, the timer is off and the over-current pin is raised on a port that is off. Both a set-power strobe and a change-clear strobe are then driven in exactly the cycle after the synchroniser output first asserts, which is the cycle whose edge qualifies the fault. The outcome is judged at the pins: the port must remain unpowered, the change bit must read 1, and no power-off event may appear, since the port was not powered. In the second, set and clear strobes hit the same port together in the table of power commands, and the port must end up off.

// File: rtl/pps_pkg.sv
package pps_pkg;
  parameter int TIME_W = 4;

  // Qualification limit picked for one port from its enable flag.
  function automatic logic [TIME_W-1:0] qual_limit(
    input logic              timer_off,
    input logic              enabled,
    input logic [TIME_W-1:0] t_en,
    input logic [TIME_W-1:0] t_dis
  );
    if (timer_off) return '0;
    return enabled ? t_en : t_dis;
  endfunction

  // Normalise a raw pin to an "asserted" flag.
  function automatic logic pin_asserted(input logic pin, input logic act_high);
    return pin == act_high;
  endfunction
endpackage

// File: rtl/pps_sync.sv
module pps_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1, stage2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= d;
      stage2 <= stage1;
    end
  end

  assign q = stage2;
endmodule

// File: rtl/pps_oc_filter.sv
module pps_oc_filter
  import pps_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              oc_act,
  input  logic              tick,
  input  logic [TIME_W-1:0] limit,
  output logic              status_o,
  output logic              trip_o
);
  localparam logic [TIME_W-1:0] CNT_MAX = '1;

  logic [TIME_W-1:0] cnt;
  logic              hit;
  logic              status_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!oc_act) begin
      cnt <= '0;
    end else if (tick && cnt != CNT_MAX) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign hit = oc_act && (cnt >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= 1'b0;
    else        status_q <= hit;
  end

  assign trip_o   = hit && !status_q;
  assign status_o = status_q;

  AST_COUNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    !oc_act |=> (cnt == '0)); // R7
  AST_STATUS_NEEDS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_q) |-> $past(oc_act)); // R11
endmodule

// File: rtl/pps_power_ctrl.sv
module pps_power_ctrl #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         gang,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] trip_i,
  output logic [N-1:0] pwr_on,
  output logic         off_evt
);
  logic [N-1:0] set_eff, clr_eff, trip_eff, pwr_nxt;

  always_comb begin
    set_eff  = gang ? {N{|set_i}}  : set_i;
    clr_eff  = gang ? {N{|clr_i}}  : clr_i;
    trip_eff = gang ? {N{|trip_i}} : trip_i;
    pwr_nxt  = (pwr_on | set_eff) & ~clr_eff & ~trip_eff;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_on  <= '0;
      off_evt <= 1'b0;
    end else begin
      pwr_on  <= pwr_nxt;
      off_evt <= |(trip_eff & pwr_on);
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_chk
    AST_TRIP_DROPS_POWER: assert property (@(posedge clk) disable iff (!rst_n)
      trip_eff[i] |=> !pwr_on[i]); // R9
    AST_POWER_NEEDS_SET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwr_on[i]) |-> $past(|set_i)); // R2
  end

  AST_GANG_ALL_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (gang && (|set_i) && !(|clr_i) && !(|trip_i)) |=> (&pwr_on)); // R3
endmodule

// File: rtl/port_power_guard.sv
module port_power_guard
  import pps_pkg::*;
#(
  parameter int NUM_PORTS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PORTS-1:0] set_pwr,
  input  logic [NUM_PORTS-1:0] clr_pwr,
  input  logic                 gang_mode,
  input  logic                 pwr_act_high,
  input  logic                 oc_act_high,
  input  logic [TIME_W-1:0]    oc_time_en,
  input  logic [TIME_W-1:0]    oc_time_dis,
  input  logic                 oc_timer_off,
  input  logic [NUM_PORTS-1:0] port_enabled,
  input  logic                 tick_1ms,
  input  logic [NUM_PORTS-1:0] oc_pin,
  input  logic [NUM_PORTS-1:0] oc_chg_clr,
  output logic [NUM_PORTS-1:0] pwr_pin,
  output logic [NUM_PORTS-1:0] oc_status,
  output logic [NUM_PORTS-1:0] oc_change,
  output logic                 pwr_off_evt
);
  logic [NUM_PORTS-1:0] oc_raw_act, oc_act, trip, pwr_on;

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_norm
    assign oc_raw_act[i] = pin_asserted(oc_pin[i], oc_act_high);
  end

  pps_sync #(.W(NUM_PORTS)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (oc_raw_act),
    .q    (oc_act)
  );

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_filt
    pps_oc_filter u_filt (
      .clk     (clk),
      .rst_n   (rst_n),
      .oc_act  (oc_act[i]),
      .tick    (tick_1ms),
      .limit   (qual_limit(oc_timer_off, port_enabled[i], oc_time_en, oc_time_dis)),
      .status_o(oc_status[i]),
      .trip_o  (trip[i])
    );
  end

  pps_power_ctrl #(.N(NUM_PORTS)) u_pwr (
    .clk    (clk),
    .rst_n  (rst_n),
    .gang   (gang_mode),
    .set_i  (set_pwr),
    .clr_i  (clr_pwr),
    .trip_i (trip),
    .pwr_on (pwr_on),
    .off_evt(pwr_off_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) oc_change <= '0;
    else        oc_change <= (oc_change & ~oc_chg_clr) | trip;
  end

  assign pwr_pin = pwr_act_high ? pwr_on : ~pwr_on;

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_chk
    AST_CHANGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (oc_change[i] && !oc_chg_clr[i]) |=> oc_change[i]); // R10
    AST_TRIP_FLAGS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      trip[i] |=> (oc_change[i] && oc_status[i])); // R10
  end

  AST_EVT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_off_evt |-> (pwr_on != $past(pwr_on))); // R12
endmodule

// File: tb/port_power_guard_tb.sv
module port_power_guard_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;

  // {gang, set[3:0], clr[3:0], expected power[3:0]}
  localparam logic [12:0] PWR_VEC [0:9] = '{
    13'b0_0001_0000_0001,
    13'b0_0100_0000_0101,
    13'b0_0000_0001_0100,
    13'b0_1010_0100_1010,
    13'b1_0000_0000_1010,
    13'b1_0001_0000_1111,
    13'b1_0000_0100_0000,
    13'b1_1000_0000_1111,
    13'b0_0000_0011_1100,
    13'b0_0001_0001_1100
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0] set_pwr = '0, clr_pwr = '0, port_enabled = 4'b0001;
  logic [NP-1:0] oc_pin = '1, oc_chg_clr = '0;
  logic gang_mode = 1'b0, pwr_act_high = 1'b1, oc_act_high = 1'b0;
  logic oc_timer_off = 1'b0, tick_1ms = 1'b0;
  logic [3:0] oc_time_en = 4'd8, oc_time_dis = 4'd3;
  logic [NP-1:0] pwr_pin, oc_status, oc_change;
  logic pwr_off_evt;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  port_power_guard #(.NUM_PORTS(NP)) u_dut (
    .clk(clk), .rst_n(rst_n), .set_pwr(set_pwr), .clr_pwr(clr_pwr),
    .gang_mode(gang_mode), .pwr_act_high(pwr_act_high), .oc_act_high(oc_act_high),
    .oc_time_en(oc_time_en), .oc_time_dis(oc_time_dis), .oc_timer_off(oc_timer_off),
    .port_enabled(port_enabled), .tick_1ms(tick_1ms), .oc_pin(oc_pin),
    .oc_chg_clr(oc_chg_clr), .pwr_pin(pwr_pin), .oc_status(oc_status),
    .oc_change(oc_change), .pwr_off_evt(pwr_off_evt)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic tick();
    tick_1ms = 1'b1;
    @(negedge clk);
    tick_1ms = 1'b0;
  endtask

  task automatic pulse_set(input logic [NP-1:0] v);
    set_pwr = v;
    @(negedge clk);
    set_pwr = '0;
  endtask

  task automatic pulse_chg_clr(input logic [NP-1:0] v);
    oc_chg_clr = v;
    @(negedge clk);
    oc_chg_clr = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    step(3);
    // R1 reset state
    chk("R1 pwr", pwr_pin, 0);
    chk("R1 status", oc_status, 0);
    chk("R1 change", oc_change, 0);
    chk("R1 evt", pwr_off_evt, 0);
    rst_n = 1'b1;
    step(3);
    chk("R1 after reset", {pwr_pin, oc_status, oc_change}, 0);

    // R2 / R3 command table
    foreach (PWR_VEC[v]) begin
      gang_mode = PWR_VEC[v][12];
      set_pwr   = PWR_VEC[v][11:8];
      clr_pwr   = PWR_VEC[v][7:4];
      @(negedge clk);
      set_pwr = '0;
      clr_pwr = '0;
      chk(PWR_VEC[v][12] ? "R3 gang cmd" : "R2 single cmd", pwr_pin, PWR_VEC[v][3:0]);
    end
    gang_mode = 1'b0;

    // R4 output polarity
    pwr_act_high = 1'b0;
    #1 chk("R4 inverted", pwr_pin, 4'b0011);
    pwr_act_high = 1'b1;
    #1 chk("R4 direct", pwr_pin, 4'b1100);

    // R5 / R6 enabled port, 8 ticks, active-low pin
    step(1);
    pulse_set(4'b0001);
    oc_pin[0] = 1'b0;
    step(3);
    for (int t = 0; t < 7; t++) tick();
    chk("R6 not yet", oc_status, 0);
    chk("R6 power held", pwr_pin, 4'b1101);
    tick();
    step(1);
    chk("R5 R6 status", oc_status, 4'b0001);
    chk("R9 power off", pwr_pin, 4'b1100);
    chk("R10 change set", oc_change, 4'b0001);
    chk("R12 evt pulse", pwr_off_evt, 1);
    step(1);
    chk("R12 evt one cycle", pwr_off_evt, 0);

    // R11 / R10 / R9 release, sticky, re-power
    oc_pin[0] = 1'b1;
    step(4);
    chk("R11 status clears", oc_status, 0);
    chk("R10 change sticky", oc_change, 4'b0001);
    chk("R9 stays off", pwr_pin, 4'b1100);
    pulse_chg_clr(4'b0001);
    chk("R10 change cleared", oc_change, 0);
    pulse_set(4'b0001);
    chk("R9 new set restores", pwr_pin, 4'b1101);

    // R7 restart on a disabled port (limit 3)
    pulse_set(4'b0010);
    oc_pin[1] = 1'b0;
    step(3);
    tick(); tick();
    oc_pin[1] = 1'b1;
    step(4);
    oc_pin[1] = 1'b0;
    step(3);
    tick(); tick();
    chk("R7 count restarted", oc_status, 0);
    tick();
    step(1);
    chk("R6 disabled limit", oc_status, 4'b0010);
    chk("R6 disabled power", pwr_pin, 4'b1101);
    oc_pin[1] = 1'b1;
    step(4);
    pulse_chg_clr(4'b0010);

    // R8 timer off, no ticks
    oc_timer_off = 1'b1;
    oc_pin[2] = 1'b0;
    step(3);
    chk("R8 immediate status", oc_status, 4'b0100);
    chk("R8 power off", pwr_pin, 4'b1001);
    oc_pin[2] = 1'b1;
    step(4);
    pulse_chg_clr(4'b0100);
    chk("R10 clear before race", oc_change, 0);

    // R9 / R10 / R12 collision: trip, set and change-clear in one cycle
    oc_pin[2] = 1'b0;
    step(2);
    set_pwr = 4'b0100;
    oc_chg_clr = 4'b0100;
    @(negedge clk);
    set_pwr = '0;
    oc_chg_clr = '0;
    chk("R9 trip beats set", pwr_pin, 4'b1001);
    chk("R10 set beats clear", oc_change, 4'b0100);
    chk("R12 no evt when off", pwr_off_evt, 0);
    oc_pin[2] = 1'b1;
    step(4);
    pulse_chg_clr(4'b0100);

    // R3 gang trip
    gang_mode = 1'b1;
    pulse_set(4'b0001);
    chk("R3 gang set", pwr_pin, 4'b1111);
    oc_pin[1] = 1'b0;
    step(3);
    chk("R3 gang trip", pwr_pin, 4'b0000);
    chk("R3 change only own port", oc_change, 4'b0010);
    oc_pin[1] = 1'b1;
    step(4);
    gang_mode = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule